// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers eight active-low interrupt request lines. Each line is armed by a falling edge, and a write-only mask then filters the armed lines. The block drives one active-low interrupt output toward the processor. When the processor services the interrupt, it reads the block's fetch address three times. The block answers with a long-branch opcode, then a high vector byte taken from a page register, then a low vector byte. The low byte is computed from a base value plus the level of the winning request times a programmable step. The first of these reads also disarms the winning line so that a new edge on it can be captured.

A cascade input accepts the interrupt output of a second controller so that several blocks can be chained. Software can inspect the block in two ways. A status read shows every armed line and disarms all of them in the same step. A polling read returns the highest unmasked level and changes nothing.

All register and fetch traffic uses a single request channel and a single response channel, each with valid/ready. Only one access is ever in flight. `req_ready` is the inverse of `rsp_valid`, so no new request is taken while a response is waiting. A waiting response keeps its data unchanged until the requester raises `rsp_ready`. Writes are taken and produce no response.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A line is armed only by a 1-to-0 change of its `irq_n_i` bit. A line that stays low does not re-arm after it has been cleared, and a rising change has no effect.
- R2: A masked line (mask bit = 1, mask written at address 0, reset value 0x00) is still armed and shows in status, but it does not pull `irq_n_o` low.
- R3: `irq_n_o` is low exactly while an unmasked line is armed or `cascade_n_i` is low. It falls in the cycle that follows the edge that arms the line.
- R4: A read of address 3 returns the armed lines, with bit i standing for line i, and disarms every line. An edge arriving in the same cycle as that read stays armed.
- R5: A read of address 4 returns 0x80 + level of the highest armed unmasked line, or 0x00 when there is none. It disarms nothing.
- R6: Priority is fixed: line 7 is highest and line 0 is lowest.
- R7: The first read of address 5 in a sequence returns 0xC0 and disarms only the winning line.
- R8: The second fetch read returns the page register (address 1). The third returns the low 7 bits of the control register (address 2) plus level × step, modulo 256, where step is 8 when control bit 7 is 1 and 4 otherwise. After the third read the sequence starts over.
- R9: If no unmasked line is armed at the first fetch read, that read and the next two fetch reads are accepted but produce no response, leaving the bus to a downstream controller.
- R10: A low `cascade_n_i` pulls `irq_n_o` low, but a locally armed unmasked line still wins the fetch.
- R11: Reads of addresses 0, 1, 2, 6 and 7 return 0x00. Writes to addresses 3 to 7 change nothing.
- R12: `req_ready` is the inverse of `rsp_valid`. A response holds its data until it is accepted. Each answered read gives exactly one response, one cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n_i | input | 8 | Request lines, armed on falling edge |
| cascade_n_i | input | 1 | Active-low interrupt from a chained controller |
| irq_n_o | output | 1 | Active-low interrupt to the processor |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register or fetch address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_data | output | 8 | Read data |

## Verification
An edge on a request line that is present at clock edge k arms the line at that edge. `irq_n_o` therefore changes one cycle later, while a change on `cascade_n_i` shows on `irq_n_o` in the same cycle. Read data appears on `rsp_valid`/`rsp_data` in the cycle after the request is accepted, and the clear caused by a status or fetch read takes effect at that same edge. The bench runs a behavioural model that is updated at each rising edge from the inputs driven at the previous falling edge. It compares every output 1 ns after each falling edge, so both the registered results and the combinational cascade path have settled before they are sampled.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam logic [2:0] ADR_MASK  = 3'd0;
  localparam logic [2:0] ADR_PAGE  = 3'd1;
  localparam logic [2:0] ADR_CTRL  = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_POLL  = 3'd4;
  localparam logic [2:0] ADR_FETCH = 3'd5;

  localparam logic [7:0] LONG_BRANCH_OP = 8'hC0;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_HIGH   = 2'd1,
    PH_LOW    = 2'd2
  } fetch_phase_t;
endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_n,
  input  logic         clr_all,
  input  logic [N-1:0] clr_one,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] fall;

  assign fall = prev_q & ~lines_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend   <= '0;
    end else begin
      prev_q <= lines_n;
      pend   <= (clr_all ? '0 : (pend & ~clr_one)) | fall;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_edge_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_q[g] && !lines_n[g]) |=> pend[g]);
  end

  assert_status_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (pend == $past(fall)));
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [LW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = LW'(i);
      end
    end
  end

  assert_top_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req >> idx) == N'(1))));
endmodule

// File: rtl/irqv_fetch_seq.sv
module irqv_fetch_seq
  import irqv_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_acc,
  input  logic          loc_any,
  input  logic [LW-1:0] loc_idx,
  input  logic [7:0]    page,
  input  logic [7:0]    ctrl,
  output logic          answer,
  output logic [7:0]    byte_o,
  output logic [N-1:0]  clr_one
);
  fetch_phase_t  ph_q;
  logic          own_q;
  logic [LW-1:0] lvl_q;
  logic [7:0]    offset;

  assign offset = ctrl[7] ? (8'(lvl_q) << 3) : (8'(lvl_q) << 2);

  always_comb begin
    unique case (ph_q)
      PH_OPCODE: begin answer = loc_any; byte_o = LONG_BRANCH_OP; end
      PH_HIGH:   begin answer = own_q;   byte_o = page; end
      default:   begin answer = own_q;   byte_o = {1'b0, ctrl[6:0]} + offset; end
    endcase
  end

  assign clr_one = (fetch_acc && ph_q == PH_OPCODE && loc_any) ? (N'(1) << loc_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_OPCODE;
      own_q <= 1'b0;
      lvl_q <= '0;
    end else if (fetch_acc) begin
      unique case (ph_q)
        PH_OPCODE: begin
          ph_q  <= PH_HIGH;
          own_q <= loc_any;
          lvl_q <= loc_idx;
        end
        PH_HIGH: ph_q <= PH_LOW;
        default: ph_q <= PH_OPCODE;
      endcase
    end
  end

  assert_silent_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_acc && ph_q == PH_OPCODE && !loc_any) |=> !answer);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_n_i,
  input  logic         cascade_n_i,
  output logic         irq_n_o,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic [2:0]   req_addr,
  input  logic [7:0]   req_wdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [7:0]   rsp_data
);
  logic [N-1:0]  mask_q;
  logic [7:0]    page_q, ctrl_q;
  logic [N-1:0]  pend, clr_one;
  logic          loc_any, fetch_ans;
  logic [LW-1:0] loc_idx;
  logic [7:0]    fetch_byte, rd_byte, poll_byte;
  logic          acc, rd_acc, wr_acc, fetch_acc, clr_all, rd_ans;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_write;
  assign wr_acc    = acc && req_write;
  assign fetch_acc = rd_acc && (req_addr == ADR_FETCH);
  assign clr_all   = rd_acc && (req_addr == ADR_STAT);

  irqv_edge_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines_n(irq_n_i),
    .clr_all(clr_all), .clr_one(clr_one), .pend(pend)
  );

  irqv_prio_enc #(.N(N), .LW(LW)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(pend & ~mask_q),
    .any(loc_any), .idx(loc_idx)
  );

  irqv_fetch_seq #(.N(N), .LW(LW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_acc(fetch_acc),
    .loc_any(loc_any), .loc_idx(loc_idx), .page(page_q), .ctrl(ctrl_q),
    .answer(fetch_ans), .byte_o(fetch_byte), .clr_one(clr_one)
  );

  assign irq_n_o   = !(loc_any || !cascade_n_i);
  assign poll_byte = loc_any ? {1'b1, (7 - LW)'(0), loc_idx} : 8'h00;

  always_comb begin
    rd_ans  = 1'b1;
    rd_byte = 8'h00;
    case (req_addr)
      ADR_STAT:  rd_byte = 8'(pend);
      ADR_POLL:  rd_byte = poll_byte;
      ADR_FETCH: begin rd_byte = fetch_byte; rd_ans = fetch_ans; end
      default:   rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      page_q    <= '0;
      ctrl_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (wr_acc) begin
        case (req_addr)
          ADR_MASK: mask_q <= req_wdata[N-1:0];
          ADR_PAGE: page_q <= req_wdata;
          ADR_CTRL: ctrl_q <= req_wdata;
          default: ;
        endcase
      end
      if (rd_acc && rd_ans) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend & ~mask_q) == '0) && cascade_n_i) |-> irq_n_o);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq_n = 8'hFF;
  logic cascade_n = 1, req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [2:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  wire irq_n_o, req_ready, rsp_valid;
  wire [7:0] rsp_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .cascade_n_i(cascade_n),
    .irq_n_o(irq_n_o), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // behavioural reference model
  logic [7:0] m_lat, m_mask, m_page, m_ctrl, m_prev, m_rd;
  bit m_rv, m_own;
  int m_ph, m_lvl;
  string m_tag = "R12", m_vtag = "R12";

  function automatic int m_top();
    for (int i = 7; i >= 0; i--) if (m_lat[i] && !m_mask[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    logic [7:0] fall, d;
    bit acc, ans;
    int w;
    string tag;
    if (!rst_n) begin
      m_lat = 0; m_mask = 0; m_page = 0; m_ctrl = 0; m_prev = 8'hFF;
      m_rv = 0; m_rd = 0; m_own = 0; m_ph = 0; m_lvl = 0;
    end else begin
      fall = m_prev & ~irq_n;
      acc = req_valid && !m_rv;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc && req_write) begin
        if (req_addr == 0) m_mask = req_wdata;
        else if (req_addr == 1) m_page = req_wdata;
        else if (req_addr == 2) m_ctrl = req_wdata;
      end
      if (acc && !req_write) begin
        ans = 1; d = 0; tag = "R11";
        if (req_addr == 3) begin d = m_lat; m_lat = 0; tag = "R4"; end
        else if (req_addr == 4) begin
          w = m_top(); d = (w < 0) ? 8'h00 : 8'(8'h80 + w); tag = "R5";
        end else if (req_addr == 5) begin
          if (m_ph == 0) begin
            w = m_top(); m_own = (w >= 0); tag = "R7";
            if (m_own) begin m_lvl = w; m_lat[w] = 0; end
            d = 8'hC0;
          end else if (m_ph == 1) begin d = m_page; tag = "R8"; end
          else begin
            d = 8'((m_ctrl & 8'h7F) + m_lvl * (m_ctrl[7] ? 8 : 4)); tag = "R8";
          end
          ans = m_own;
          m_ph = (m_ph + 1) % 3;
        end
        if (ans) begin m_rv = 1; m_rd = d; m_tag = tag; m_vtag = "R12"; end
        else m_vtag = "R9";
      end
      m_lat = m_lat | fall;
      m_prev = irq_n;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3", 8'(irq_n_o), 8'(!((m_lat & ~m_mask) != 0 || !cascade_n)));
      chk("R12", 8'(req_ready), 8'(!m_rv));
      chk(m_vtag, 8'(rsp_valid), 8'(m_rv));
      if (m_rv) chk(m_tag, rsp_data, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = v;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v, output bit got);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    #1; got = rsp_valid; v = rsp_data;
  endtask

  task automatic rd_exp(input string tag, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v; bit g;
    rd(a, v, g);
    chk(tag, 8'(g), 8'd1);
    chk(tag, v, e);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irq_n[line] = 0;
    @(negedge clk); irq_n[line] = 1;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v; bit g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R3 reset irq", 8'(irq_n_o), 8'd1);
    chk("R12 reset rsp", 8'(rsp_valid), 8'd0);
    // R1: held-low line arms once
    @(negedge clk); irq_n[2] = 0;
    @(negedge clk); #1; chk("R1 irq low after edge", 8'(irq_n_o), 8'd0);
    rd_exp("R1", 3, 8'h04);
    rd_exp("R1 no rearm on level", 3, 8'h00);
    @(negedge clk); irq_n[2] = 1;
    // R2: masked line latched, interrupt quiet
    wr(0, 8'h01);
    pulse(0);
    @(negedge clk); #1; chk("R2 masked quiet", 8'(irq_n_o), 8'd1);
    rd_exp("R2 status shows masked", 3, 8'h01);
    // R5/R6 priority
    pulse(3); pulse(6);
    rd_exp("R6", 4, 8'h86);
    // R7/R8 vector fetch
    wr(1, 8'h9A); wr(2, 8'h10);
    rd_exp("R7", 5, 8'hC0);
    rd_exp("R8 page", 5, 8'h9A);
    rd_exp("R8 low step4", 5, 8'h28);
    rd_exp("R7 only winner cleared", 4, 8'h83);
    wr(2, 8'h91);
    rd_exp("R7", 5, 8'hC0);
    rd_exp("R8 page", 5, 8'h9A);
    rd_exp("R8 low step8", 5, 8'h29);
    rd_exp("R5 none", 4, 8'h00);
    // R10/R9 cascade only
    @(negedge clk); cascade_n = 0;
    #1; chk("R10 cascade pulls low", 8'(irq_n_o), 8'd0);
    for (int k = 0; k < 3; k++) begin
      rd(5, v, g);
      chk("R9 no answer", 8'(g), 8'd0);
    end
    pulse(5);
    rd_exp("R10 local wins", 5, 8'hC0);
    rd_exp("R8", 5, 8'h9A);
    rd_exp("R8", 5, 8'h39);
    @(negedge clk); cascade_n = 1;
    // R11
    pulse(1);
    wr(3, 8'hFF); wr(7, 8'h55);
    rd_exp("R11 wo reads zero", 0, 8'h00);
    rd_exp("R11 unused reads zero", 6, 8'h00);
    rd_exp("R11 write to status ignored", 3, 8'h02);
    // R4 edge during status read survives
    @(negedge clk); irq_n[4] = 0; req_valid = 1; req_write = 0; req_addr = 3;
    @(negedge clk); req_valid = 0; irq_n[4] = 1;
    rd_exp("R4 edge survives clear", 3, 8'h10);
    // R12 back-pressure
    pulse(7);
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_addr = 4;
    @(negedge clk); req_addr = 3;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R12 held", 8'(rsp_valid), 8'd1);
      chk("R12 data held", rsp_data, 8'h87);
    end
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);
    // mixed traffic checked by the model
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) irq_n[$urandom_range(0, 7)] ^= 1'b1;
      cascade_n = ($urandom_range(0, 9) != 0);
      req_valid = $urandom_range(0, 1);
      req_write = ($urandom_range(0, 3) == 0);
      req_addr = 3'($urandom_range(0, 7));
      req_wdata = 8'($urandom);
      rsp_ready = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk); req_valid = 0; rsp_ready = 1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule